// File: doc/BRIEF.md
# Multi-Channel Edge Capture Unit

This block timestamps signal transitions on up to four external inputs. A shared timebase divides the system clock by a programmable factor. The divided clock advances a free-running counter that wraps. Each input passes through a two-flop synchronizer. An edge detector then compares the synchronized sample with the sample taken one cycle earlier.

Each channel has its own 2-bit edge selector. When a channel sees the kind of transition it was told to watch for, it copies the current counter value into its own capture register and raises a pending flag. The pending flags, masked by per-channel enables, are ORed into one interrupt line. Software clears the flags through a write-one-to-clear acknowledge register.

Software typically uses the unit as follows:
1. Arm a channel for rising edges.
2. Take a capture.
3. Flip the selector to falling edges.
4. Subtract successive captures to recover the high and low times of a pulse train.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, all readable registers read zero and `irq` is low.
- R2: Edge-select code 0 ignores the input, 1 reacts to a low-to-high change, 2 to a high-to-low change, and 3 to either change. A qualifying change on channel k sets bit k+1 of the pending register at byte offset 0x08. The selector of channel k sits in bits [1:0] at offset 0x10+4k.
- R3: The capture register of channel k (offset 0x20+4k) receives the counter value. An input change first seen by the rising clock edge N is captured at edge N+2, using the counter value held just before that edge.
- R4: While the run bit is set, the counter advances by one every (P+1) clocks. P is the 5-bit prescale field in bits [8:4] of the control register. While the run bit is clear, the counter holds its value.
- R5: While the run bit (control bit 10) is clear, no input change captures a value or sets a pending bit.
- R6: Bit k+1 of the enable register at offset 0x04 unmasks channel k. `irq` is high exactly when some pending bit and its enable bit are both set.
- R7: Writing the acknowledge register at offset 0x0C clears each pending bit whose matching data bit (bits [4:1]) is 1. Writing 0x1FF clears all of them. A capture in the same cycle as its acknowledge leaves the bit set.
- R8: A qualifying change on a channel whose pending bit is still set overwrites that channel's capture register with the newer count.
- R9: Zero bits in an acknowledge write, and any write to the pending register, leave the pending bits unchanged.
- R10: The control register at offset 0x00 reads back the run bit at bit 10 and the prescale field at bits [8:4], with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | NUM_CH | Asynchronous inputs to be timestamped |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume the following:
- Each write strobe lasts one cycle, with address and data stable around the sampling edge.
- The counter is never reloaded, so between two edges it either holds or steps by exactly one.
- A pending bit can only leave the set state through an acknowledge that coincides with no capture.

The stimulus follows these rules:
- It drives the bus and inputs only on the falling clock edge.
- It toggles one input at a time and holds every input level for at least three clocks, so each change crosses the synchronizer cleanly.
- It applies each register write for exactly one clock.
- It times one acknowledge to land on the capture edge, to exercise the collision rule.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    // Edge-select codes: bit 0 arms rising edges, bit 1 arms falling edges
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RISE = 2'd1,
        SEL_FALL = 2'd2,
        SEL_BOTH = 2'd3
    } edge_sel_e;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int MAX_CH   = 4;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SEL0  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CAP0  = 8'h20;

    // Field positions
    localparam int RUN_BIT  = 10;
    localparam int PRE_LSB  = 4;
    localparam int CH_LSB   = 1;

endpackage

// File: rtl/ecu_timebase.sv
module ecu_timebase #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (en_i) begin
            if (tb_q.div >= pre_i) begin
                tb_d.div = '0;
                tb_d.cnt = tb_q.cnt + 1'b1;
            end else begin
                tb_d.div = tb_q.div + 1'b1;
            end
        end else begin
            tb_d.div = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign cnt_o = tb_q.cnt;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_o));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
    import ecu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             run_i,
    input  logic             sel_wr_i,
    input  logic [1:0]       sel_wdata_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [1:0]       sel_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             evt_o
);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             prev;
        edge_sel_e        sel;
        logic [CNT_W-1:0] cap;
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    logic      rise_seen, fall_seen;

    assign rise_seen = ch_q.sync2 & ~ch_q.prev;
    assign fall_seen = ~ch_q.sync2 & ch_q.prev;

    always_comb begin
        evt_o = run_i & ((ch_q.sel[0] & rise_seen) | (ch_q.sel[1] & fall_seen));
        ch_d       = ch_q;
        ch_d.sync1 = pin_i;
        ch_d.sync2 = ch_q.sync1;
        ch_d.prev  = ch_q.sync2;
        if (sel_wr_i) ch_d.sel = edge_sel_e'(sel_wdata_i);
        if (evt_o)    ch_d.cap = count_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign sel_o = ch_q.sel;
    assign cap_o = ch_q.cap;

    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_o |=> $stable(cap_o));

    // R2
    sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.sel == SEL_NONE) |-> !evt_o);

endmodule

// File: rtl/ecu_irq.sv
module ecu_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              en_wr_i,
    input  logic [NUM_CH-1:0] en_wdata_i,
    input  logic              ack_wr_i,
    input  logic [NUM_CH-1:0] ack_wdata_i,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] pend_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] pend;
    } irq_state_t;

    irq_state_t ir_d, ir_q;
    logic [NUM_CH-1:0] clr_mask;

    always_comb begin
        clr_mask = ack_wr_i ? ack_wdata_i : '0;
        ir_d     = ir_q;
        if (en_wr_i) ir_d.en = en_wdata_i;
        ir_d.pend = (ir_q.pend & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign en_o   = ir_q.en;
    assign pend_o = ir_q.pend;
    assign irq_o  = |(ir_q.pend & ir_q.en);

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

    // R7
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr_i |=> ((pend_o & $past(ack_wdata_i) & ~$past(evt_i)) == '0));

    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o == '0) |-> !irq_o);

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] cap_in,
    output logic              irq
);

    localparam int SEL_STRIDE = 4;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [CNT_W-1:0]  count;
    logic [NUM_CH-1:0] evt_vec;
    logic [NUM_CH-1:0] en_vec, pend_vec;
    logic [1:0]        sel_arr [NUM_CH];
    logic [CNT_W-1:0]  cap_arr [NUM_CH];
    logic              ctrl_wr, ien_wr, ack_wr;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata;

    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign ien_wr  = bus_wr && (bus_addr == OFS_IEN);
    assign ack_wr  = bus_wr && (bus_addr == OFS_ACK);

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.run = bus_wdata[RUN_BIT];
            ctrl_d.pre = bus_wdata[PRE_LSB +: PRE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    ecu_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (ctrl_q.run),
        .pre_i (ctrl_q.pre),
        .cnt_o (count)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [7:0] SEL_OFS = 8'(OFS_SEL0 + SEL_STRIDE * g);
        logic sel_wr;
        assign sel_wr = bus_wr && (bus_addr == SEL_OFS);

        ecu_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_i       (cap_in[g]),
            .run_i       (ctrl_q.run),
            .sel_wr_i    (sel_wr),
            .sel_wdata_i (bus_wdata[1:0]),
            .count_i     (count),
            .sel_o       (sel_arr[g]),
            .cap_o       (cap_arr[g]),
            .evt_o       (evt_vec[g])
        );
    end

    ecu_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_vec),
        .en_wr_i     (ien_wr),
        .en_wdata_i  (bus_wdata[CH_LSB +: NUM_CH]),
        .ack_wr_i    (ack_wr),
        .ack_wdata_i (bus_wdata[CH_LSB +: NUM_CH]),
        .en_o        (en_vec),
        .pend_o      (pend_vec),
        .irq_o       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            bus_rdata[RUN_BIT]           = ctrl_q.run;
            bus_rdata[PRE_LSB +: PRE_W]  = ctrl_q.pre;
        end else if (bus_addr == OFS_IEN) begin
            bus_rdata[CH_LSB +: NUM_CH]  = en_vec;
        end else if (bus_addr == OFS_PEND) begin
            bus_rdata[CH_LSB +: NUM_CH]  = pend_vec;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == 8'(OFS_SEL0 + SEL_STRIDE * i)) bus_rdata = {30'd0, sel_arr[i]};
            if (bus_addr == 8'(OFS_CAP0 + SEL_STRIDE * i)) bus_rdata = 32'(cap_arr[i]);
        end
    end

    // R5
    idle_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |-> (evt_vec == '0));

endmodule

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int WDOG_LIMIT = 5000;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_IEN  = 8'h04;
    localparam logic [7:0] A_PEND = 8'h08;
    localparam logic [7:0] A_ACK  = 8'h0C;

    // {channel[5:4], select[3:2], new level[1], expect capture[0]}
    localparam int NVEC = 12;
    localparam logic [5:0] VEC [NVEC] = '{
        {2'd0, 2'd1, 1'b1, 1'b1},
        {2'd0, 2'd1, 1'b0, 1'b0},
        {2'd1, 2'd2, 1'b1, 1'b0},
        {2'd1, 2'd2, 1'b0, 1'b1},
        {2'd2, 2'd3, 1'b1, 1'b1},
        {2'd2, 2'd3, 1'b0, 1'b1},
        {2'd3, 2'd0, 1'b1, 1'b0},
        {2'd3, 2'd0, 1'b0, 1'b0},
        {2'd3, 2'd1, 1'b1, 1'b1},
        {2'd0, 2'd2, 1'b1, 1'b0},
        {2'd0, 2'd2, 1'b0, 1'b1},
        {2'd1, 2'd3, 1'b1, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] cap_in = '0;
    logic           irq;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int last_wr_edge = 0;
    int run_edge = 0;
    int pscale = 0;
    bit done = 0;
    int exp_cap [NCH];

    edge_capture_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WDOG_LIMIT && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WDOG_LIMIT);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr     = a;
        bus_wdata    = d;
        bus_wr       = 1'b1;
        last_wr_edge = cyc + 1;
        @(negedge clk);
        bus_wr       = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive_pin(input int ch, input logic v, output int n);
        @(negedge clk);
        cap_in[ch] = v;
        n = cyc + 1;
        repeat (3) @(negedge clk);
    endtask

    function automatic int cap_of(input int n);
        return (n + 1 - run_edge) / (pscale + 1);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] rv;
        int n;
        int c1;
        for (int i = 0; i < NCH; i++) exp_cap[i] = 0;

        do_reset();
        // R1 reset state
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 32'h0);
        rd(A_IEN, rv);  chk("R1 enable", rv, 32'h0);
        rd(A_PEND, rv); chk("R1 pending", rv, 32'h0);
        rd(8'h14, rv);  chk("R1 select ch1", rv, 32'h0);
        rd(8'h2C, rv);  chk("R1 capture ch3", rv, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R5 no capture while run bit is clear
        wr(8'h10, 32'd3);
        drive_pin(0, 1'b1, n);
        rd(A_PEND, rv); chk("R5 pending while idle", rv, 32'h0);
        rd(8'h20, rv);  chk("R5 capture while idle", rv, 32'h0);
        drive_pin(0, 1'b0, n);

        // start the timebase, prescale 0
        pscale = 0;
        wr(A_CTRL, 32'h400);
        run_edge = last_wr_edge;
        rd(A_CTRL, rv); chk("R10 ctrl readback", rv, 32'h400);

        // table-driven edge selection and capture
        for (int v = 0; v < NVEC; v++) begin
            int ch;
            logic hit;
            ch  = int'(VEC[v][5:4]);
            hit = VEC[v][0];
            wr(A_ACK, 32'h1FF);
            wr(8'(8'h10 + 4 * ch), {30'd0, VEC[v][3:2]});
            drive_pin(ch, VEC[v][1], n);
            rd(A_PEND, rv);
            chk($sformatf("R2 vector %0d pending", v), rv, hit ? (32'h1 << (ch + 1)) : 32'h0);
            if (hit) exp_cap[ch] = cap_of(n);
            rd(8'(8'h20 + 4 * ch), rv);
            chk($sformatf("R3 vector %0d capture", v), rv, exp_cap[ch]);
        end

        // R6 interrupt masking; channel 1 is pending now
        wr(A_IEN, 32'h0);
        chk("R6 irq all masked", {31'd0, irq}, 32'h0);
        wr(A_IEN, 32'h2);
        chk("R6 irq other channel", {31'd0, irq}, 32'h0);
        wr(A_IEN, 32'h4);
        chk("R6 irq unmasked", {31'd0, irq}, 32'h1);
        rd(A_IEN, rv); chk("R6 enable readback", rv, 32'h4);

        // R9 / R7 partial acknowledge; channel 2 armed for both edges
        drive_pin(2, 1'b1, n);
        exp_cap[2] = cap_of(n);
        rd(A_PEND, rv); chk("R2 two pending", rv, 32'h0C);
        wr(A_ACK, 32'h0);
        rd(A_PEND, rv); chk("R9 zero ack keeps bits", rv, 32'h0C);
        wr(A_PEND, 32'h0);
        rd(A_PEND, rv); chk("R9 pending write ignored", rv, 32'h0C);
        wr(A_ACK, 32'h4);
        rd(A_PEND, rv); chk("R7 single ack", rv, 32'h08);
        chk("R6 irq after ack", {31'd0, irq}, 32'h0);
        wr(A_ACK, 32'h1FF);
        rd(A_PEND, rv); chk("R7 ack all", rv, 32'h0);

        // R8 overwrite while pending
        drive_pin(2, 1'b0, n);
        c1 = cap_of(n);
        drive_pin(2, 1'b1, n);
        exp_cap[2] = cap_of(n);
        rd(8'h28, rv); chk("R8 newer capture kept", rv, exp_cap[2]);
        chk("R8 differs from first", {31'd0, (c1 != exp_cap[2])}, 32'h1);
        rd(A_PEND, rv); chk("R8 still pending", rv, 32'h08);
        wr(A_ACK, 32'h1FF);

        // R7 capture and acknowledge in the same cycle: capture wins
        wr(8'h1C, 32'd3);
        @(negedge clk);
        cap_in[3] = 1'b0;
        n = cyc + 1;
        @(negedge clk);
        wr(A_ACK, 32'h1FF);
        rd(A_PEND, rv); chk("R7 set wins over ack", rv, 32'h10);
        rd(8'h2C, rv);  chk("R3 collision capture", rv, cap_of(n));

        // R4 prescaled timebase after a fresh reset
        do_reset();
        pscale = 3;
        wr(A_CTRL, 32'h430);
        run_edge = last_wr_edge;
        rd(A_CTRL, rv); chk("R10 prescale readback", rv, 32'h430);
        wr(8'h10, 32'd1);
        repeat (9) @(negedge clk);
        drive_pin(0, 1'b1, n);
        rd(8'h20, rv); chk("R4 prescale 3 capture", rv, cap_of(n));
        rd(A_PEND, rv); chk("R2 rise after prescale", rv, 32'h2);

        summary();
    end

endmodule